// File: doc/BRIEF.md
# TDM Timeslot Channel Mapper

This block connects four subscriber channels to a shared serial backplane made of 32 timeslots of 8 bits each. It handles two bearer channels (B1, B2), one control channel and one signalling channel. A frame pulse marks the start of each 256-bit frame. From it the block counts bit positions, shifts its own bytes out MSB first in the timeslots it owns, and captures the bytes that other devices put into those same timeslots. It leaves every other timeslot undriven by holding the output-enable of that stream low. One cycle before its ninth bit position it raises a delayed frame pulse. The next device in a daisy chain uses that pulse as its own frame pulse and so lands one timeslot later (slots 1 and 17).

There are two layouts. In single-stream mode, the data stream carries only the two bearer channels and the control stream stays silent. In dual-stream mode, the control stream also carries the control and signalling channels, in an order chosen by a mode bit. A swap input exchanges the two bearer channels between the backplane and the parallel side.

Transmit bytes come in as one bundle of four through a valid/ready handshake. A single holding register takes one bundle. It releases the bundle into the frame that starts next, and it applies back-pressure until then. Received bytes leave with a one-cycle strobe per channel. The receive side has no ready, because a TDM frame cannot pause.

Top module: `tdm_slot_mapper`

## Requirements
- R1: The clock edge at which `fp_in` is sampled high is frame position 0. Each later edge advances one position, wrapping after 255. Position p is timeslot p/8, bit p%8, sent MSB first. The output bit for position p is driven in the cycle after the edge of position p, and the input bit for position p is sampled at that edge.
- R2: After the first frame pulse, `ser_data_oe` is high exactly in timeslots 0 and 16. Backplane slot 0 carries the line B1 byte and slot 16 the line B2 byte.
- R3: With `mode_dual`=0 (sampled at the frame start), `ser_ctl_oe` stays low and nothing received on `ser_ctl_in` raises a strobe.
- R4: With `mode_dual`=1, the control stream is driven in slots 0 and 16. With `mode_order`=0, slot 0 holds the control byte and slot 16 the signalling byte. With `mode_order`=1 the two are swapped.
- R5: Before the first frame pulse, and in every timeslot other than 0 and 16, both output-enables are low.
- R6: `fp_out` is high for exactly one cycle per frame: the cycle after the edge of position 7. A chained device therefore sees it at the edge where this device reaches position 8.
- R7: With `bswap`=1, line B1 uses backplane slot 16 and line B2 uses slot 0, both for transmit and for receive.
- R8: `mode_dual`, `mode_order` and `bswap` are sampled only at the frame-start edge. Their values at any other edge have no effect on that frame.
- R9: After the edge that samples the last bit of an owned timeslot, `rx_strobe[k]` is high for one cycle and `rx_bytes[8k+7:8k]` holds the byte. The index k is 0 for B1, 1 for B2, 2 for control and 3 for signalling. The byte holds its value until the next capture for that channel.
- R10: `tx_ready` is high while the holding register is empty. A bundle is taken on an edge with `tx_valid` and `tx_ready` both high. `tx_ready` then stays low until the next frame start, when the bundle becomes that frame's transmit data. Offers made while `tx_ready` is low are ignored.
- R11: A frame that starts with an empty holding register transmits 8'hFF in every owned slot.
- R12: While `rst_n` is low: both output-enables are low, `fp_out` is low, `rx_strobe` is 0 and `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_in | input | 1 | Frame pulse, marks position 0 |
| fp_out | output | 1 | Delayed frame pulse for the next chained device |
| mode_dual | input | 1 | 0 = single stream, 1 = dual stream |
| mode_order | input | 1 | Control/signalling slot order in dual mode |
| bswap | input | 1 | Exchange bearer channels |
| tx_valid | input | 1 | Transmit bundle offered |
| tx_ready | output | 1 | Holding register empty |
| tx_b1 | input | 8 | Line B1 transmit byte |
| tx_b2 | input | 8 | Line B2 transmit byte |
| tx_ctl | input | 8 | Control transmit byte |
| tx_sig | input | 8 | Signalling transmit byte |
| ser_data_in | input | 1 | Data stream serial input |
| ser_data_out | output | 1 | Data stream serial output |
| ser_data_oe | output | 1 | Data stream drive enable |
| ser_ctl_in | input | 1 | Control stream serial input |
| ser_ctl_out | output | 1 | Control stream serial output |
| ser_ctl_oe | output | 1 | Control stream drive enable |
| rx_strobe | output | 4 | Per-channel receive strobe |
| rx_bytes | output | 32 | Last received byte per channel |

## Verification
Some relations are checked on every cycle:
- The control stream never drives without the data stream.
- The delayed pulse is a single cycle that falls inside an owned data slot.
- Receive strobes come at most one per stream, and a control-stream strobe always has a data-stream strobe beside it.
- An accepted bundle always leaves the holding register full.

Other behaviour only shows up in the bench's frame-by-frame scenarios:
- bit order and slot content under every mode combination;
- bearer swap in both directions;
- mode pins being ignored away from the frame start;
- idle fill;
- offers dropped while the holding register is full.

// File: rtl/tdm_map_pkg.sv
package tdm_map_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NUM_CHANS = 4;
  localparam int unsigned CH_B1     = 0;
  localparam int unsigned CH_B2     = 1;
  localparam int unsigned CH_CTL    = 2;
  localparam int unsigned CH_SIG    = 3;

  typedef struct packed {
    logic              dual;
    logic              order;
    logic              swap;
    logic [BYTE_W-1:0] b1;
    logic [BYTE_W-1:0] b2;
    logic [BYTE_W-1:0] ctl;
    logic [BYTE_W-1:0] sig;
  } frame_cfg_t;
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer import tdm_map_pkg::*; #(
  parameter int unsigned SLOTS       = 32,
  parameter int unsigned DELAY_SLOTS = 1,
  localparam int unsigned FRAME_LEN  = SLOTS * BYTE_W,
  localparam int unsigned POS_W      = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fp_in,
  output logic             frame_start,
  output logic             synced,
  output logic [POS_W-1:0] pos_next,
  output logic             fp_out
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);
  localparam logic [POS_W-1:0] DLY_POS  = POS_W'(DELAY_SLOTS * BYTE_W - 1);

  logic [POS_W-1:0] pos_q;
  logic             synced_q;
  logic             fp_out_q;

  always_comb begin
    frame_start = fp_in;
    synced      = synced_q | fp_in;
    if (fp_in)                 pos_next = '0;
    else if (pos_q == LAST_POS) pos_next = '0;
    else                       pos_next = pos_q + POS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      synced_q <= 1'b0;
      fp_out_q <= 1'b0;
    end else begin
      pos_q    <= pos_next;
      synced_q <= synced;
      fp_out_q <= synced && (pos_next == DLY_POS);
    end
  end

  assign fp_out = fp_out_q;
endmodule

// File: rtl/tdm_tx_stage.sv
module tdm_tx_stage import tdm_map_pkg::*; #(
  parameter logic [BYTE_W-1:0] IDLE_BYTE = {BYTE_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              mode_dual,
  input  logic              mode_order,
  input  logic              bswap,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_b1,
  input  logic [BYTE_W-1:0] tx_b2,
  input  logic [BYTE_W-1:0] tx_ctl,
  input  logic [BYTE_W-1:0] tx_sig,
  output frame_cfg_t        cfg_eff
);
  logic                        hold_full_q;
  logic [NUM_CHANS*BYTE_W-1:0] hold_q;
  frame_cfg_t                  act_q;
  frame_cfg_t                  act_new;
  logic                        accept;

  always_comb begin
    tx_ready      = !hold_full_q;
    accept        = tx_valid && !hold_full_q;
    act_new.dual  = mode_dual;
    act_new.order = mode_order;
    act_new.swap  = bswap;
    if (hold_full_q) begin
      act_new.b1  = hold_q[CH_B1*BYTE_W +: BYTE_W];
      act_new.b2  = hold_q[CH_B2*BYTE_W +: BYTE_W];
      act_new.ctl = hold_q[CH_CTL*BYTE_W +: BYTE_W];
      act_new.sig = hold_q[CH_SIG*BYTE_W +: BYTE_W];
    end else begin
      act_new.b1  = IDLE_BYTE;
      act_new.b2  = IDLE_BYTE;
      act_new.ctl = IDLE_BYTE;
      act_new.sig = IDLE_BYTE;
    end
    cfg_eff = frame_start ? act_new : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full_q <= 1'b0;
      hold_q      <= '0;
      act_q       <= '0;
    end else begin
      if (frame_start) act_q <= act_new;
      if (accept) begin
        hold_q      <= {tx_sig, tx_ctl, tx_b2, tx_b1};
        hold_full_q <= 1'b1;
      end else if (frame_start) begin
        hold_full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdm_lane.sv
module tdm_lane import tdm_map_pkg::*; #(
  parameter int unsigned SLOTS   = 32,
  parameter int unsigned SLOT_LO = 0,
  parameter int unsigned SLOT_HI = 16,
  localparam int unsigned POS_W  = $clog2(SLOTS * BYTE_W),
  localparam int unsigned BIT_W  = $clog2(BYTE_W),
  localparam int unsigned SLOT_W = POS_W - BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              synced,
  input  logic              enable,
  input  logic [POS_W-1:0]  pos_next,
  input  logic [BYTE_W-1:0] byte_lo,
  input  logic [BYTE_W-1:0] byte_hi,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              ser_oe,
  output logic              cap_lo,
  output logic              cap_hi,
  output logic [BYTE_W-1:0] cap_byte
);
  logic [SLOT_W-1:0] slot;
  logic [BIT_W-1:0]  bidx;
  logic              own_lo, own_hi, last_bit, tx_bit;
  logic [BYTE_W-1:0] sel_byte;
  logic [BYTE_W-2:0] shift_q;
  logic              out_q, oe_q;

  always_comb begin
    slot     = pos_next[POS_W-1:BIT_W];
    bidx     = pos_next[BIT_W-1:0];
    own_lo   = synced && enable && (slot == SLOT_W'(SLOT_LO));
    own_hi   = synced && enable && (slot == SLOT_W'(SLOT_HI));
    sel_byte = own_hi ? byte_hi : byte_lo;
    tx_bit   = sel_byte[BIT_W'(BYTE_W-1) - bidx];
    last_bit = (bidx == BIT_W'(BYTE_W-1));
    cap_lo   = own_lo && last_bit;
    cap_hi   = own_hi && last_bit;
    cap_byte = {shift_q, ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      out_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      shift_q <= cap_byte[BYTE_W-2:0];
      out_q   <= (own_lo || own_hi) && tx_bit;
      oe_q    <= own_lo || own_hi;
    end
  end

  assign ser_out = out_q;
  assign ser_oe  = oe_q;
endmodule

// File: rtl/tdm_slot_mapper.sv
module tdm_slot_mapper import tdm_map_pkg::*; #(
  parameter int unsigned SLOTS             = 32,
  parameter int unsigned SLOT_LO           = 0,
  parameter int unsigned SLOT_HI           = 16,
  parameter int unsigned CHAIN_DELAY_SLOTS = 1,
  parameter logic [BYTE_W-1:0] IDLE_BYTE   = {BYTE_W{1'b1}}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fp_in,
  output logic                        fp_out,
  input  logic                        mode_dual,
  input  logic                        mode_order,
  input  logic                        bswap,
  input  logic                        tx_valid,
  output logic                        tx_ready,
  input  logic [BYTE_W-1:0]           tx_b1,
  input  logic [BYTE_W-1:0]           tx_b2,
  input  logic [BYTE_W-1:0]           tx_ctl,
  input  logic [BYTE_W-1:0]           tx_sig,
  input  logic                        ser_data_in,
  output logic                        ser_data_out,
  output logic                        ser_data_oe,
  input  logic                        ser_ctl_in,
  output logic                        ser_ctl_out,
  output logic                        ser_ctl_oe,
  output logic [NUM_CHANS-1:0]        rx_strobe,
  output logic [NUM_CHANS*BYTE_W-1:0] rx_bytes
);
  localparam int unsigned POS_W = $clog2(SLOTS * BYTE_W);
  localparam int unsigned LANES = 2;

  logic             frame_start, synced;
  logic [POS_W-1:0] pos_next;
  frame_cfg_t       cfg;

  tdm_frame_timer #(.SLOTS(SLOTS), .DELAY_SLOTS(CHAIN_DELAY_SLOTS)) u_timer (
    .clk(clk), .rst_n(rst_n), .fp_in(fp_in), .frame_start(frame_start),
    .synced(synced), .pos_next(pos_next), .fp_out(fp_out)
  );

  tdm_tx_stage #(.IDLE_BYTE(IDLE_BYTE)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .mode_dual(mode_dual), .mode_order(mode_order), .bswap(bswap),
    .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_b1(tx_b1), .tx_b2(tx_b2), .tx_ctl(tx_ctl), .tx_sig(tx_sig),
    .cfg_eff(cfg)
  );

  logic              lane_en  [LANES];
  logic [BYTE_W-1:0] lane_lo  [LANES];
  logic [BYTE_W-1:0] lane_hi  [LANES];
  logic              lane_in  [LANES];
  logic              lane_out [LANES];
  logic              lane_oe  [LANES];
  logic              lane_clo [LANES];
  logic              lane_chi [LANES];
  logic [BYTE_W-1:0] lane_cap [LANES];

  always_comb begin
    lane_en[0] = 1'b1;
    lane_lo[0] = cfg.swap ? cfg.b2 : cfg.b1;
    lane_hi[0] = cfg.swap ? cfg.b1 : cfg.b2;
    lane_in[0] = ser_data_in;
    lane_en[1] = cfg.dual;
    lane_lo[1] = cfg.order ? cfg.sig : cfg.ctl;
    lane_hi[1] = cfg.order ? cfg.ctl : cfg.sig;
    lane_in[1] = ser_ctl_in;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tdm_lane #(.SLOTS(SLOTS), .SLOT_LO(SLOT_LO), .SLOT_HI(SLOT_HI)) u_lane (
      .clk(clk), .rst_n(rst_n), .synced(synced), .enable(lane_en[g]),
      .pos_next(pos_next), .byte_lo(lane_lo[g]), .byte_hi(lane_hi[g]),
      .ser_in(lane_in[g]), .ser_out(lane_out[g]), .ser_oe(lane_oe[g]),
      .cap_lo(lane_clo[g]), .cap_hi(lane_chi[g]), .cap_byte(lane_cap[g])
    );
  end

  assign ser_data_out = lane_out[0];
  assign ser_data_oe  = lane_oe[0];
  assign ser_ctl_out  = lane_out[1];
  assign ser_ctl_oe   = lane_oe[1];

  logic [NUM_CHANS-1:0] chan_hit;

  always_comb begin
    chan_hit[CH_B1]  = (lane_clo[0] && !cfg.swap)  || (lane_chi[0] && cfg.swap);
    chan_hit[CH_B2]  = (lane_chi[0] && !cfg.swap)  || (lane_clo[0] && cfg.swap);
    chan_hit[CH_CTL] = (lane_clo[1] && !cfg.order) || (lane_chi[1] && cfg.order);
    chan_hit[CH_SIG] = (lane_chi[1] && !cfg.order) || (lane_clo[1] && cfg.order);
  end

  for (genvar k = 0; k < NUM_CHANS; k++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rx_strobe[k]                  <= 1'b0;
        rx_bytes[k*BYTE_W +: BYTE_W]  <= '0;
      end else begin
        rx_strobe[k] <= chan_hit[k];
        if (chan_hit[k]) rx_bytes[k*BYTE_W +: BYTE_W] <= lane_cap[k/2];
      end
    end
  end
endmodule

// File: rtl/tdm_slot_mapper_chk.sv
module tdm_slot_mapper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fp_out,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       ser_data_oe,
  input logic       ser_ctl_oe,
  input logic [3:0] rx_strobe
);
  assert_ctl_within_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_ctl_oe |-> ser_data_oe);

  assert_oe_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_data_oe) |=> ser_data_oe);

  assert_fp_out_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fp_out |=> !fp_out);

  assert_fp_out_in_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fp_out |-> ser_data_oe);

  assert_rx_per_stream_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_strobe[1:0]) && $onehot0(rx_strobe[3:2]));

  assert_rx_ctl_paired_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_strobe[3:2]) |-> (|rx_strobe[1:0]));

  assert_accept_fills_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

bind tdm_slot_mapper tdm_slot_mapper_chk u_chk (.*);

// File: tb/tdm_slot_mapper_test.sv
module tdm_slot_mapper_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fp_in = 1'b0, mode_dual = 1'b0, mode_order = 1'b0, bswap = 1'b0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_b1 = '0, tx_b2 = '0, tx_ctl = '0, tx_sig = '0;
  logic ser_data_in = 1'b0, ser_ctl_in = 1'b0;
  logic fp_out, tx_ready, ser_data_out, ser_data_oe, ser_ctl_out, ser_ctl_oe;
  logic [3:0]  rx_strobe;
  logic [31:0] rx_bytes;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_slot_mapper uut (
    .clk(clk), .rst_n(rst_n), .fp_in(fp_in), .fp_out(fp_out),
    .mode_dual(mode_dual), .mode_order(mode_order), .bswap(bswap),
    .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_b1(tx_b1), .tx_b2(tx_b2), .tx_ctl(tx_ctl), .tx_sig(tx_sig),
    .ser_data_in(ser_data_in), .ser_data_out(ser_data_out), .ser_data_oe(ser_data_oe),
    .ser_ctl_in(ser_ctl_in), .ser_ctl_out(ser_ctl_out), .ser_ctl_oe(ser_ctl_oe),
    .rx_strobe(rx_strobe), .rx_bytes(rx_bytes)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // expected state of the frame under check
  bit e_dual, e_order, e_swap, e_idle;
  logic [7:0] e_b [4];
  logic [7:0] e_rd [2];
  logic [7:0] e_rc [2];
  bit pend_ok = 1'b0;
  logic [7:0] pend_b [4];
  bit have_prev = 1'b0;
  int prev_p = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_mask(input int p);
    logic [3:0] m = '0;
    int slot = p / 8;
    if (p % 8 == 7 && (slot == 0 || slot == 16)) begin
      if (slot == 0) begin
        m[e_swap ? 1 : 0] = 1'b1;
        if (e_dual) m[e_order ? 3 : 2] = 1'b1;
      end else begin
        m[e_swap ? 0 : 1] = 1'b1;
        if (e_dual) m[e_order ? 2 : 3] = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic logic [7:0] exp_rx(input int ch);
    case (ch)
      0: return e_swap ? e_rd[1] : e_rd[0];
      1: return e_swap ? e_rd[0] : e_rd[1];
      2: return e_order ? e_rc[1] : e_rc[0];
      default: return e_order ? e_rc[0] : e_rc[1];
    endcase
  endfunction

  task automatic check_pos(input int p);
    int slot = p / 8;
    int b = p % 8;
    bit owned = (slot == 0 || slot == 16);
    logic [7:0] db, cb;
    logic [3:0] m;
    string dreq;
    dreq = e_idle ? "R11" : (e_swap ? "R7" : "R1/R2");
    check(ser_data_oe == owned, "R2/R5 data oe", ser_data_oe, owned);
    if (owned) begin
      db = (slot == 0) ? (e_swap ? e_b[1] : e_b[0]) : (e_swap ? e_b[0] : e_b[1]);
      check(ser_data_out == db[7-b], {dreq, " data bit"}, ser_data_out, db[7-b]);
    end
    check(ser_ctl_oe == (owned && e_dual), e_dual ? "R4/R8 ctl oe" : "R3 ctl oe", ser_ctl_oe, owned && e_dual);
    if (owned && e_dual) begin
      cb = (slot == 0) ? (e_order ? e_b[3] : e_b[2]) : (e_order ? e_b[2] : e_b[3]);
      check(ser_ctl_out == cb[7-b], e_idle ? "R11 ctl bit" : "R4 ctl bit", ser_ctl_out, cb[7-b]);
    end
    check(fp_out == (p == 7), "R6 fp_out", fp_out, p == 7);
    m = exp_mask(p);
    check(rx_strobe == m, "R9 rx strobe", rx_strobe, m);
    for (int k = 0; k < 4; k++)
      if (m[k]) check(rx_bytes[k*8 +: 8] == exp_rx(k), "R9/R7 rx byte", rx_bytes[k*8 +: 8], exp_rx(k));
  endtask

  task automatic run_frame(input bit give, input bit dual, input bit order, input bit swap);
    for (int p = 0; p < 256; p++) begin
      int slot = p / 8;
      int b = p % 8;
      @(negedge clk);
      if (have_prev) check_pos(prev_p);
      if (p == 0) begin
        e_dual = dual; e_order = order; e_swap = swap;
        e_idle = !pend_ok;
        for (int k = 0; k < 4; k++) e_b[k] = pend_ok ? pend_b[k] : 8'hFF;
        pend_ok = 1'b0;
        for (int k = 0; k < 2; k++) begin
          e_rd[k] = 8'($urandom);
          e_rc[k] = 8'($urandom);
        end
      end
      fp_in = (p == 0);
      mode_dual  = (p == 0) ? dual  : 1'($urandom);
      mode_order = (p == 0) ? order : 1'($urandom);
      bswap      = (p == 0) ? swap  : 1'($urandom);
      if (slot == 0)       begin ser_data_in = e_rd[0][7-b]; ser_ctl_in = e_rc[0][7-b]; end
      else if (slot == 16) begin ser_data_in = e_rd[1][7-b]; ser_ctl_in = e_rc[1][7-b]; end
      else begin ser_data_in = 1'($urandom); ser_ctl_in = 1'($urandom); end
      if (give && p == 100) begin
        check(tx_ready == 1'b1, "R10 ready empty", tx_ready, 1);
        tx_valid = 1'b1;
        tx_b1 = 8'($urandom); tx_b2 = 8'($urandom); tx_ctl = 8'($urandom); tx_sig = 8'($urandom);
        pend_b[0] = tx_b1; pend_b[1] = tx_b2; pend_b[2] = tx_ctl; pend_b[3] = tx_sig;
        pend_ok = 1'b1;
      end else if (give && p == 101) begin
        tx_valid = 1'b0;
        check(tx_ready == 1'b0, "R10 ready full", tx_ready, 0);
      end else if (give && p == 150) begin
        check(tx_ready == 1'b0, "R10 held full", tx_ready, 0);
        tx_valid = 1'b1;
        tx_b1 = ~pend_b[0]; tx_b2 = ~pend_b[1]; tx_ctl = ~pend_b[2]; tx_sig = ~pend_b[3];
      end else begin
        tx_valid = 1'b0;
      end
      have_prev = 1'b1;
      prev_p = p;
    end
  endtask

  initial begin
    void'($urandom(32'd1717));
    repeat (3) @(negedge clk);
    check(ser_data_oe == 0 && ser_ctl_oe == 0, "R12 oe in reset", {ser_data_oe, ser_ctl_oe}, 0);
    check(fp_out == 0, "R12 fp_out in reset", fp_out, 0);
    check(rx_strobe == 0, "R12 strobe in reset", rx_strobe, 0);
    check(tx_ready == 1, "R12 ready in reset", tx_ready, 1);
    rst_n = 1'b1;
    // free-running before any frame pulse
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(ser_data_oe == 0 && ser_ctl_oe == 0, "R5 no drive before sync", {ser_data_oe, ser_ctl_oe}, 0);
      check(fp_out == 0 && rx_strobe == 0, "R5 quiet before sync", {fp_out, rx_strobe}, 0);
      ser_data_in = 1'($urandom); ser_ctl_in = 1'($urandom);
      mode_dual = 1'($urandom);
      if (i == 5) begin
        tx_valid = 1'b1;
        tx_b1 = 8'h81; tx_b2 = 8'h42; tx_ctl = 8'h3C; tx_sig = 8'hA5;
        pend_b[0] = 8'h81; pend_b[1] = 8'h42; pend_b[2] = 8'h3C; pend_b[3] = 8'hA5;
        pend_ok = 1'b1;
      end else begin
        tx_valid = 1'b0;
      end
      if (i == 6) check(tx_ready == 0, "R10 accepted before sync", tx_ready, 0);
    end
    // directed corners
    run_frame(1'b1, 1'b0, 1'b0, 1'b0);
    run_frame(1'b0, 1'b1, 1'b0, 1'b0);
    run_frame(1'b1, 1'b1, 1'b1, 1'b0);
    run_frame(1'b1, 1'b1, 1'b1, 1'b1);
    run_frame(1'b1, 1'b0, 1'b1, 1'b1);
    run_frame(1'b1, 1'b1, 1'b0, 1'b1);
    // random frames
    for (int f = 0; f < 16; f++)
      run_frame(($urandom % 4) != 0, 1'($urandom), 1'($urandom), 1'($urandom));
    @(negedge clk);
    check_pos(prev_p);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule